// File: doc/BRIEF.md
# I2C Master Clock Pacer with Slave Stretch Support

This block sets the pace of SCL for an I2C master. A down-counter paces each half of the clock. It is loaded from a 7-bit reload input, and it counts only on selected phases of a four-phase instruction cycle. The block drives the clock open-drain style through a single pull-low enable. When the enable is clear, the line is released. A master sequencer uses the block during transmit, receive, and repeated-start or stop timing. The sequencer watches a one-cycle strobe that marks the end of each full high phase.

The block reads the real SCL level back through a two-flop synchronizer. After the block releases the line, the counter stops while the synchronized level is still low, because a slave may be holding the clock. When the line is first seen high, the counter reloads and the high phase starts from its full length. A stretching slave therefore lengthens the high phase and never shortens it.

Top module: `scl_pacer`

## Requirements
- R1: While `en_i` is low, the block releases SCL (`scl_pull_o`=0), keeps `stall_o` and `half_done_o` at 0, and holds the counter at the reload value. Deasserting `en_i` in any phase releases the line from the next clock on.
- R2: A tick is a clock cycle in which `qphase_i` is 1 or 3, which gives two ticks per four-phase cycle. Each low phase keeps `scl_pull_o` at 1 for exactly N ticks, where N is `reload_i`.
- R3: When a low phase ends, the block releases the line. While the synchronized SCL level is low, `stall_o` is 1 and the counter does not change. With no stretching, the stall lasts 3 cycles: two synchronizer stages plus one decision cycle. A slave holding SCL low for H cycles adds H cycles.
- R4: The first high sample of SCL reloads the counter and starts a high phase. That phase lasts exactly N ticks, with `scl_pull_o`=0 and `stall_o`=0, however long the slave held the line low.
- R5: At the end of each high phase, `scl_pull_o` returns to 1. `half_done_o` pulses for exactly one cycle, in the first cycle of the new low phase, and is never high while the line is released.
- R6: A `reload_i` of 0 counts as N=1, so each phase lasts one tick.
- R7: While reset is asserted, `scl_pull_o`, `half_done_o` and `stall_o` are all 0.
- R8: The counter holds at zero until the next reload and never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable for clock generation |
| qphase_i | input | 2 | Current phase of the four-phase instruction cycle |
| reload_i | input | 7 | Half-period reload count in ticks |
| scl_i | input | 1 | Sampled SCL wire level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| half_done_o | output | 1 | One-cycle strobe at the end of a high phase |
| stall_o | output | 1 | Line released but not yet seen high |

## Verification
The bench sweeps several reload values, including 0, 1 and the maximum. It pairs them with several slave hold lengths, from none to longer than a half period. For each pair it counts the ticks in the low and high phases and the stall cycles. Equal low and high tick counts under a long hold show that the counter reloads after the line rises, rather than carrying on through the stall. An exact stall length of H+3 shows that the counter freezes on the synchronized level and not on the raw one. Directed runs disable the block in the middle of a low phase and in the middle of a stall, and they check the outputs during reset.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_WAITH = 2'd2,
    ST_HIGH  = 2'd3
  } pace_state_e;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/scl_phase_dec.sv
module scl_phase_dec #(
  parameter int unsigned PH_W = 2,
  parameter logic [(1<<PH_W)-1:0] TICK_MASK = 4'b1010
) (
  input  logic [PH_W-1:0] qphase_i,
  output logic            tick_o
);

  localparam int unsigned NPH = 1 << PH_W;

  logic [NPH-1:0] hit;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign hit[p] = TICK_MASK[p] && (qphase_i == PH_W'(p));
  end

  assign tick_o = |hit;

endmodule

// File: rtl/scl_baud_cnt.sv
module scl_baud_cnt #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o) else $error("counter left zero without reload"); // R8

endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_pacer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic zero_i,
  input  logic line_hi_i,
  output logic load_o,
  output logic dec_o,
  output logic pull_o,
  output logic stall_o,
  output logic strobe_o
);

  pace_state_e state_q, state_d;
  logic        strobe_q, strobe_d;
  logic        counting;

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    strobe_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        load_o = 1'b1;
        if (en_i) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (!en_i) begin
          state_d = ST_IDLE;
          load_o  = 1'b1;
        end else if (zero_i) begin
          state_d = ST_WAITH;
        end
      end
      ST_WAITH: begin
        if (!en_i) begin
          state_d = ST_IDLE;
          load_o  = 1'b1;
        end else if (line_hi_i) begin
          state_d = ST_HIGH;
          load_o  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!en_i) begin
          state_d = ST_IDLE;
          load_o  = 1'b1;
        end else if (zero_i) begin
          state_d  = ST_LOW;
          load_o   = 1'b1;
          strobe_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        load_o  = 1'b1;
      end
    endcase
  end

  assign counting = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign dec_o    = en_i && counting && tick_i && !zero_i && !load_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
    end
  end

  assign pull_o   = (state_q == ST_LOW);
  assign stall_o  = (state_q == ST_WAITH);
  assign strobe_o = strobe_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o) else $error("strobe wider than one cycle"); // R5

  AST_STROBE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> pull_o) else $error("strobe while line released"); // R5

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int unsigned RLD_W       = 7,
  parameter int unsigned PH_W        = 2,
  parameter logic [(1<<PH_W)-1:0] TICK_MASK = 4'b1010,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PH_W-1:0]  qphase_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             scl_i,
  output logic             scl_pull_o,
  output logic             half_done_o,
  output logic             stall_o
);

  localparam logic [RLD_W-1:0] MIN_CNT = RLD_W'(1);

  logic             rst_q;
  logic             tick;
  logic             line_hi;
  logic             load;
  logic             dec;
  logic             zero;
  logic [RLD_W-1:0] cnt;
  logic [RLD_W-1:0] rl_eff;

  assign rl_eff = (reload_i == '0) ? MIN_CNT : reload_i;

  scl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q)
  );

  scl_phase_dec #(.PH_W(PH_W), .TICK_MASK(TICK_MASK)) u_phase (
    .qphase_i (qphase_i),
    .tick_o   (tick)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q),
    .line_i (scl_i),
    .line_o (line_hi)
  );

  scl_baud_cnt #(.W(RLD_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_i     (load),
    .load_val_i (rl_eff),
    .dec_i      (dec),
    .cnt_o      (cnt),
    .zero_o     (zero)
  );

  scl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .en_i      (en_i),
    .tick_i    (tick),
    .zero_i    (zero),
    .line_hi_i (line_hi),
    .load_o    (load),
    .dec_o     (dec),
    .pull_o    (scl_pull_o),
    .stall_o   (stall_o),
    .strobe_o  (half_done_o)
  );

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_q)
    !en_i |=> (!scl_pull_o && !stall_o && !half_done_o)) else $error("line not released when disabled"); // R1

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_q)
    (stall_o && !line_hi && en_i) |=> $stable(cnt)) else $error("counter moved during stall"); // R3

  AST_RELOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_q)
    (stall_o && line_hi && en_i) |=>
      (cnt == (($past(reload_i) == '0) ? MIN_CNT : $past(reload_i)))) else $error("no reload on line high"); // R4

endmodule

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;

  typedef struct packed {
    logic [6:0] rl;
    logic [7:0] hold;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{rl: 7'd5,   hold: 8'd0},
    '{rl: 7'd1,   hold: 8'd0},
    '{rl: 7'd0,   hold: 8'd0},
    '{rl: 7'd3,   hold: 8'd4},
    '{rl: 7'd12,  hold: 8'd40},
    '{rl: 7'd127, hold: 8'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       run_ph;
  logic [1:0] qph;
  logic [6:0] rl;
  logic       scl_line;
  logic       pull, hd, stall;

  int errors = 0;
  int checks = 0;
  int hold_len = 0;
  int hold_cnt = 0;
  int lo_acc = 0, hi_acc = 0, st_acc = 0;
  int last_lo = 0, last_hi = 0, last_st = 0;
  int n_strobe = 0, bad_strobe = 0, dbl_strobe = 0;
  logic prev_pull = 1'b0, prev_stall = 1'b0, prev_hd = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = !pull && (hold_cnt == 0);

  scl_pacer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .qphase_i    (qph),
    .reload_i    (rl),
    .scl_i       (scl_line),
    .scl_pull_o  (pull),
    .half_done_o (hd),
    .stall_o     (stall)
  );

  always @(negedge clk) begin
    if (!run_ph) qph <= 2'd0;
    else         qph <= qph + 2'd1;
  end

  always @(negedge clk) begin
    #1;
    if (pull && !prev_pull) begin
      last_hi = hi_acc;
      hi_acc  = 0;
    end
    if (!pull && prev_pull) begin
      last_lo  = lo_acc;
      lo_acc   = 0;
      hold_cnt = hold_len;
    end else if (hold_cnt > 0) begin
      hold_cnt = hold_cnt - 1;
    end
    if (stall) st_acc = st_acc + 1;
    else if (prev_stall) begin
      last_st = st_acc;
      st_acc  = 0;
    end
    if (qph[0] && pull) lo_acc = lo_acc + 1;
    if (qph[0] && !pull && !stall && en) hi_acc = hi_acc + 1;
    if (hd) begin
      n_strobe = n_strobe + 1;
      if (!pull) bad_strobe = bad_strobe + 1;
      if (prev_hd) dbl_strobe = dbl_strobe + 1;
    end
    prev_pull  = pull;
    prev_stall = stall;
    prev_hd    = hd;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wait_strobes(input int n);
    int guard = 0;
    while (n_strobe < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    #2;
  endtask

  task automatic run_vec(input logic [6:0] r, input int h);
    int n_exp;
    @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);
    rl       = r;
    hold_len = h;
    lo_acc = 0; hi_acc = 0; st_acc = 0;
    n_strobe = 0; bad_strobe = 0; dbl_strobe = 0;
    en = 1'b1;
    wait_strobes(2);
    n_exp = (r == 0) ? 1 : int'(r);
    chk((r == 0) ? "R6 zero reload low ticks" : "R2 low ticks", last_lo, n_exp);
    chk((r == 0) ? "R6 zero reload high ticks" : "R4 high ticks", last_hi, n_exp);
    chk("R3 stall cycles", last_st, h + 3);
    chk("R5 strobe only while pulled low", bad_strobe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog on all requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    en     = 1'b0;
    run_ph = 1'b0;
    rl     = 7'd4;
    repeat (4) @(negedge clk);
    #1;
    chk("R7 pull in reset", int'(pull), 0);
    chk("R7 strobe in reset", int'(hd), 0);
    chk("R7 stall in reset", int'(stall), 0);
    rst_n  = 1'b1;
    run_ph = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk("R1 released while disabled", int'(pull), 0);
    chk("R1 no stall while disabled", int'(stall), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i].rl, int'(VECS[i].hold));
    end
    chk("R5 strobe single cycle", dbl_strobe, 0);

    // R1: disable in the middle of a low phase
    @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);
    rl = 7'd20; hold_len = 0;
    en = 1'b1;
    repeat (8) @(negedge clk);
    #1;
    chk("R2 pulled low in low phase", int'(pull), 1);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 release after disable in low", int'(pull), 0);
    chk("R1 no strobe after disable", int'(hd), 0);

    // R1 and R3: disable during a long stretch
    repeat (4) @(negedge clk);
    rl = 7'd2; hold_len = 60;
    en = 1'b1;
    begin
      int guard = 0;
      while (!stall && guard < 200) begin
        @(negedge clk);
        #1;
        guard++;
      end
    end
    repeat (10) @(negedge clk);
    #1;
    chk("R3 stall held by slave", int'(stall), 1);
    chk("R3 line released during stall", int'(pull), 0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 stall cleared after disable", int'(stall), 0);
    chk("R1 released after disable in stall", int'(pull), 0);

    summary();
    $finish;
  end

endmodule